// File: doc/BRIEF.md
# Dual-Port RAM with Address-Contention Arbitration

This block is a synchronous 2048 x 8 memory with two fully symmetric ports, called left and right. Each port has its own enable, write select, output enable, 11-bit address, write data and read data, so either side can act as the writer while the other reads. Writes land on the rising clock edge. Read data is registered and appears one cycle after the request.

When both ports are enabled on the same address, a contention arbiter decides which port owns that location. Ownership goes to the port that was already sitting on that address in the previous cycle. If both arrive in the same cycle, the left port wins. The other port sees its busy output rise in the same cycle, and any write it attempts while busy is dropped. Reads are never blocked. Once the collision clears, busy falls at once, and a write that the losing port is still holding is then committed on the next edge.

A mode input picks master or slave operation, so several devices can be combined into a wider word. In master mode the block drives its own busy outputs and ignores the busy inputs. In slave mode it does no arbitration: its busy outputs stay low, and each port's externally supplied busy input only gates that port's writes.

Top module: `dpc_ram_top`

## Requirements
- R1: A word written on either port at a given address is returned by a read of that address on either port. Read data is registered: a read requested in cycle N appears on the read data output in cycle N+1. A read in the same cycle as a write to that address returns the word held before the write.
- R2: In master mode, a port's busy output is high in the same cycle, combinationally, only when both ports are enabled, both addresses are equal and the opposite port owns the location. At most one busy output is high at a time, and busy falls in the cycle that the addresses differ or either enable drops.
- R3: In master mode, when one port was enabled on an address in the previous cycle and the opposite port newly arrives on the same address, the port already present wins and the newcomer gets busy.
- R4: In master mode, when both ports arrive on the same address in the same cycle, the left port wins and the right port's busy is high.
- R5: Ownership is kept for as long as both ports stay enabled on the unchanged matching address, whatever their write or output-enable selects do.
- R6: A write attempted by a port while it is blocked does not change memory. A port is blocked when its busy output is high in master mode, or when its busy input is high in slave mode.
- R7: A write that the losing port keeps asserting is committed at the first clock edge after its busy falls.
- R8: In slave mode (master_mode = 0) both busy outputs stay low and no arbitration is done. If both ports write one address in the same cycle, the left data is stored. In master mode the busy inputs have no effect.
- R9: A port's read data is zero unless, in the previous cycle, that port was enabled with its write select low and its output enable high. A port that is busy still reads normally.
- R10: After reset, both read data outputs are zero and both busy outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1 = generate busy internally, 0 = take busy from the busy inputs |
| lft_en | input | 1 | Left port enable |
| lft_wr | input | 1 | Left port write select (1 = write, 0 = read) |
| lft_oe | input | 1 | Left port output enable |
| lft_addr | input | 11 | Left port address |
| lft_wdata | input | 8 | Left port write data |
| lft_rdata | output | 8 | Left port registered read data |
| lft_busy | output | 1 | Left port busy, driven in master mode |
| lft_busy_in | input | 1 | Left port external busy, used in slave mode |
| rgt_en | input | 1 | Right port enable |
| rgt_wr | input | 1 | Right port write select (1 = write, 0 = read) |
| rgt_oe | input | 1 | Right port output enable |
| rgt_addr | input | 11 | Right port address |
| rgt_wdata | input | 8 | Right port write data |
| rgt_rdata | output | 8 | Right port registered read data |
| rgt_busy | output | 1 | Right port busy, driven in master mode |
| rgt_busy_in | input | 1 | Right port external busy, used in slave mode |

## Verification
The arbitration properties assume the mode input is held steady while the ports contend. They also assume a "new arrival" is judged only against the previous cycle's enable and address. The stimulus therefore changes master_mode only while both ports are idle, and it changes port inputs only on the falling edge. Before any slave-mode collision or inhibited write is judged, the bench first writes the affected addresses, so that it never relies on uninitialised memory.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    localparam int NUM_PORTS = 2;
    localparam int PORT_L    = 0;
    localparam int PORT_R    = 1;
endpackage

// File: rtl/dpc_arbiter.sv
module dpc_arbiter #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              busy_l,
    output logic              busy_r
);
    import dpc_pkg::*;

    typedef struct packed {
        owner_e            owner;
        logic              l_en;
        logic [ADDR_W-1:0] l_addr;
        logic              r_en;
        logic [ADDR_W-1:0] r_addr;
    } arb_state_t;

    arb_state_t st_d, st_q;
    owner_e     own_now;
    logic       match, l_held, r_held;

    always_comb begin
        st_d   = st_q;
        match  = l_en && r_en && (l_addr == r_addr);
        // a port is "held" if it sat on this same address last cycle
        l_held = l_en && st_q.l_en && (st_q.l_addr == l_addr);
        r_held = r_en && st_q.r_en && (st_q.r_addr == r_addr);

        if (!match) begin
            own_now = OWN_NONE;
        end else if ((st_q.owner != OWN_NONE) && l_held && r_held) begin
            own_now = st_q.owner;
        end else if (r_held && !l_held) begin
            own_now = OWN_RIGHT;
        end else begin
            own_now = OWN_LEFT;
        end

        st_d.owner  = own_now;
        st_d.l_en   = l_en;
        st_d.l_addr = l_addr;
        st_d.r_en   = r_en;
        st_d.r_addr = r_addr;

        busy_l = master_mode && (own_now == OWN_RIGHT);
        busy_r = master_mode && (own_now == OWN_LEFT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_NONE, l_en: 1'b0, l_addr: '0, r_en: 1'b0, r_addr: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dpc_port_gate.sv
module dpc_port_gate #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              en,
    input  logic              wr,
    input  logic              oe,
    input  logic              busy_int,
    input  logic              busy_ext,
    input  logic [DATA_W-1:0] mem_rd,
    output logic              we,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic        blocked, rd_req;

    always_comb begin
        st_d    = st_q;
        blocked = master_mode ? busy_int : busy_ext;
        we      = en && wr && !blocked;
        rd_req  = en && !wr && oe;
        st_d.rdata = rd_req ? mem_rd : '0;
        rdata   = st_q.rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dpc_mem_array.sv
module dpc_mem_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [DATA_W-1:0] wdata_l,
    input  logic              we_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] wdata_r,
    output logic [DATA_W-1:0] rd_l,
    output logic [DATA_W-1:0] rd_r
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_comb begin
        rd_l = cells[addr_l];
        rd_r = cells[addr_r];
    end

    // right first, left last: left data stands on a same-address collision
    always_ff @(posedge clk) begin
        if (we_r) cells[addr_r] <= wdata_r;
        if (we_l) cells[addr_l] <= wdata_l;
    end
endmodule

// File: rtl/dpc_ram_top.sv
module dpc_ram_top #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              lft_en,
    input  logic              lft_wr,
    input  logic              lft_oe,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic [DATA_W-1:0] lft_wdata,
    output logic [DATA_W-1:0] lft_rdata,
    output logic              lft_busy,
    input  logic              lft_busy_in,
    input  logic              rgt_en,
    input  logic              rgt_wr,
    input  logic              rgt_oe,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic [DATA_W-1:0] rgt_wdata,
    output logic [DATA_W-1:0] rgt_rdata,
    output logic              rgt_busy,
    input  logic              rgt_busy_in
);
    import dpc_pkg::*;

    logic              en_v    [NUM_PORTS];
    logic              wr_v    [NUM_PORTS];
    logic              oe_v    [NUM_PORTS];
    logic              bint_v  [NUM_PORTS];
    logic              bext_v  [NUM_PORTS];
    logic              we_v    [NUM_PORTS];
    logic [DATA_W-1:0] mrd_v   [NUM_PORTS];
    logic [DATA_W-1:0] rdat_v  [NUM_PORTS];
    logic              lft_we, rgt_we;

    always_comb begin
        en_v[PORT_L]   = lft_en;      en_v[PORT_R]   = rgt_en;
        wr_v[PORT_L]   = lft_wr;      wr_v[PORT_R]   = rgt_wr;
        oe_v[PORT_L]   = lft_oe;      oe_v[PORT_R]   = rgt_oe;
        bext_v[PORT_L] = lft_busy_in; bext_v[PORT_R] = rgt_busy_in;
        bint_v[PORT_L] = lft_busy;    bint_v[PORT_R] = rgt_busy;
        lft_we    = we_v[PORT_L];
        rgt_we    = we_v[PORT_R];
        lft_rdata = rdat_v[PORT_L];
        rgt_rdata = rdat_v[PORT_R];
    end

    dpc_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_mode (master_mode),
        .l_en        (lft_en),
        .l_addr      (lft_addr),
        .r_en        (rgt_en),
        .r_addr      (rgt_addr),
        .busy_l      (lft_busy),
        .busy_r      (rgt_busy)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpc_port_gate #(.DATA_W(DATA_W)) u_gate (
            .clk         (clk),
            .rst_n       (rst_n),
            .master_mode (master_mode),
            .en          (en_v[p]),
            .wr          (wr_v[p]),
            .oe          (oe_v[p]),
            .busy_int    (bint_v[p]),
            .busy_ext    (bext_v[p]),
            .mem_rd      (mrd_v[p]),
            .we          (we_v[p]),
            .rdata       (rdat_v[p])
        );
    end

    dpc_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .we_l    (lft_we),
        .addr_l  (lft_addr),
        .wdata_l (lft_wdata),
        .we_r    (rgt_we),
        .addr_r  (rgt_addr),
        .wdata_r (rgt_wdata),
        .rd_l    (mrd_v[PORT_L]),
        .rd_r    (mrd_v[PORT_R])
    );
endmodule

// File: rtl/dpc_chk.sv
module dpc_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              lft_en,
    input logic              lft_wr,
    input logic              lft_oe,
    input logic [ADDR_W-1:0] lft_addr,
    input logic [DATA_W-1:0] lft_rdata,
    input logic              lft_busy,
    input logic              lft_busy_in,
    input logic              lft_we,
    input logic              rgt_en,
    input logic              rgt_wr,
    input logic              rgt_oe,
    input logic [ADDR_W-1:0] rgt_addr,
    input logic [DATA_W-1:0] rgt_rdata,
    input logic              rgt_busy,
    input logic              rgt_busy_in,
    input logic              rgt_we
);
    // R2
    busy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lft_busy, rgt_busy}));

    // R2
    busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lft_busy || rgt_busy) |-> (lft_en && rgt_en && (lft_addr == rgt_addr)));

    // R4
    tie_left_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && lft_en && rgt_en && (lft_addr == rgt_addr)
         && !$past(lft_en) && !$past(rgt_en)) |-> (rgt_busy && !lft_busy));

    // R5
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && rgt_busy) ##1 (master_mode && lft_en && rgt_en
         && $stable(lft_addr) && $stable(rgt_addr)) |-> rgt_busy);

    // R6
    master_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && (lft_busy || rgt_busy)) |-> !(lft_busy && lft_we) && !(rgt_busy && rgt_we));

    // R6
    slave_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> !(lft_busy_in && lft_we) && !(rgt_busy_in && rgt_we));

    // R7
    held_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && $past(master_mode) && $past(lft_busy) && !lft_busy && lft_en && lft_wr) |-> lft_we);

    // R8
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (!lft_busy && !rgt_busy));

    // R9
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(lft_en && lft_oe && !lft_wr) |-> (lft_rdata == '0));

    // R9
    rd_idle_zero_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rgt_en && rgt_oe && !rgt_wr) |-> (rgt_rdata == '0));
endmodule

bind dpc_ram_top dpc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .lft_en      (lft_en),
    .lft_wr      (lft_wr),
    .lft_oe      (lft_oe),
    .lft_addr    (lft_addr),
    .lft_rdata   (lft_rdata),
    .lft_busy    (lft_busy),
    .lft_busy_in (lft_busy_in),
    .lft_we      (lft_we),
    .rgt_en      (rgt_en),
    .rgt_wr      (rgt_wr),
    .rgt_oe      (rgt_oe),
    .rgt_addr    (rgt_addr),
    .rgt_rdata   (rgt_rdata),
    .rgt_busy    (rgt_busy),
    .rgt_busy_in (rgt_busy_in),
    .rgt_we      (rgt_we)
);

// File: tb/sim_dpc_ram_top.sv
`timescale 1ns/1ps
module sim_dpc_ram_top;
    localparam int AW = 11;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_mode = 1'b1;
    logic          lft_en = 0, lft_wr = 0, lft_oe = 0, lft_busy_in = 0;
    logic [AW-1:0] lft_addr = '0;
    logic [DW-1:0] lft_wdata = '0;
    logic          rgt_en = 0, rgt_wr = 0, rgt_oe = 0, rgt_busy_in = 0;
    logic [AW-1:0] rgt_addr = '0;
    logic [DW-1:0] rgt_wdata = '0;
    logic [DW-1:0] lft_rdata, rgt_rdata;
    logic          lft_busy, rgt_busy;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [DW-1:0] refm [1 << AW];

    always #4 clk = ~clk;

    dpc_ram_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .lft_en(lft_en), .lft_wr(lft_wr), .lft_oe(lft_oe), .lft_addr(lft_addr),
        .lft_wdata(lft_wdata), .lft_rdata(lft_rdata), .lft_busy(lft_busy),
        .lft_busy_in(lft_busy_in),
        .rgt_en(rgt_en), .rgt_wr(rgt_wr), .rgt_oe(rgt_oe), .rgt_addr(rgt_addr),
        .rgt_wdata(rgt_wdata), .rgt_rdata(rgt_rdata), .rgt_busy(rgt_busy),
        .rgt_busy_in(rgt_busy_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic drv_l(input logic en, input logic wr, input logic oe,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        lft_en = en; lft_wr = wr; lft_oe = oe; lft_addr = a; lft_wdata = d;
    endtask

    task automatic drv_r(input logic en, input logic wr, input logic oe,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        rgt_en = en; rgt_wr = wr; rgt_oe = oe; rgt_addr = a; rgt_wdata = d;
    endtask

    task automatic idle();
        drv_l(0, 0, 0, '0, '0);
        drv_r(0, 0, 0, '0, '0);
    endtask

    task automatic write_one(input bit right, input logic [AW-1:0] a, input logic [DW-1:0] d);
        idle();
        if (right) drv_r(1, 1, 0, a, d); else drv_l(1, 1, 0, a, d);
        tick();
        refm[a] = d;
        idle();
    endtask

    task automatic read_chk(input bit right, input logic [AW-1:0] a, input string tag);
        idle();
        if (right) drv_r(1, 0, 1, a, '0); else drv_l(1, 0, 1, a, '0);
        tick();
        chk(tag, right ? rgt_rdata : lft_rdata, refm[a]);
        idle();
    endtask

    task automatic t_reset();
        chk("R10 lft_rdata after reset", lft_rdata, 0);
        chk("R10 rgt_rdata after reset", rgt_rdata, 0);
        chk("R10 busy after reset", {lft_busy, rgt_busy}, 0);
    endtask

    task automatic t_basic();
        write_one(0, 11'h010, 8'h5A);
        read_chk(1, 11'h010, "R1 right reads left write");
        write_one(1, 11'h7FF, 8'hC4);
        read_chk(0, 11'h7FF, "R1 left reads right write at top address");
        // output enable low: no data
        idle();
        drv_r(1, 0, 0, 11'h010, '0);
        tick();
        chk("R9 rdata zero with oe low", rgt_rdata, 0);
        idle();
        tick();
        chk("R9 rdata zero when idle", lft_rdata, 0);
    endtask

    task automatic t_simul();
        write_one(0, 11'h020, 8'h00);
        tick();
        drv_l(1, 1, 0, 11'h020, 8'h11);
        drv_r(1, 1, 0, 11'h020, 8'h22);
        #1;
        chk("R4 right busy on tie", rgt_busy, 1);
        chk("R4 left not busy on tie", lft_busy, 0);
        tick();
        refm[11'h020] = 8'h11;
        idle();
        read_chk(1, 11'h020, "R6 losing right write dropped");
    endtask

    task automatic t_stagger();
        write_one(0, 11'h030, 8'h33);
        tick();
        drv_r(1, 0, 1, 11'h030, '0);
        tick();
        drv_l(1, 1, 0, 11'h030, 8'h77);
        #1;
        chk("R3 newcomer left busy", lft_busy, 1);
        chk("R3 holder right not busy", rgt_busy, 0);
        tick();
        chk("R1 same-cycle read returns old word", rgt_rdata, 8'h33);
        lft_oe = 1'b1;
        #1;
        chk("R5 busy kept while addresses unchanged", lft_busy, 1);
        tick();
        chk("R6 busy write left memory unchanged", rgt_rdata, 8'h33);
        drv_r(0, 0, 0, '0, '0);
        #1;
        chk("R2 busy falls when other enable drops", lft_busy, 0);
        tick();
        refm[11'h030] = 8'h77;
        idle();
        read_chk(1, 11'h030, "R7 held write completes after release");
        // address divergence releases busy
        drv_l(1, 0, 1, 11'h031, '0);
        tick();
        drv_r(1, 0, 1, 11'h031, '0);
        #1;
        chk("R2 right busy on match", rgt_busy, 1);
        drv_r(1, 0, 1, 11'h032, '0);
        #1;
        chk("R2 busy falls when addresses differ", rgt_busy, 0);
        tick();
        idle();
    endtask

    task automatic t_loser_read();
        write_one(1, 11'h040, 8'h4C);
        tick();
        drv_l(1, 0, 1, 11'h040, '0);
        tick();
        drv_r(1, 0, 1, 11'h040, '0);
        #1;
        chk("R3 late right reader busy", rgt_busy, 1);
        tick();
        chk("R9 busy port still reads", rgt_rdata, 8'h4C);
        chk("R9 owner reads", lft_rdata, 8'h4C);
        idle();
        tick();
    endtask

    task automatic t_slave();
        write_one(0, 11'h050, 8'h00);
        write_one(0, 11'h052, 8'h0F);
        write_one(0, 11'h053, 8'h00);
        write_one(0, 11'h054, 8'h00);
        tick();
        master_mode = 1'b0;
        drv_l(1, 1, 0, 11'h050, 8'hA1);
        drv_r(1, 1, 0, 11'h050, 8'hB2);
        #1;
        chk("R8 slave busy outputs low", {lft_busy, rgt_busy}, 0);
        tick();
        refm[11'h050] = 8'hA1;
        idle();
        read_chk(1, 11'h050, "R8 slave collision keeps left data");
        rgt_busy_in = 1'b1;
        drv_r(1, 1, 0, 11'h052, 8'hC3);
        drv_l(1, 1, 0, 11'h053, 8'h3C);
        tick();
        refm[11'h053] = 8'h3C;
        idle();
        rgt_busy_in = 1'b0;
        read_chk(0, 11'h052, "R6 slave busy input blocks right write");
        read_chk(0, 11'h053, "R8 left write unaffected by right busy input");
        tick();
        master_mode = 1'b1;
        lft_busy_in = 1'b1;
        write_one(0, 11'h054, 8'h96);
        lft_busy_in = 1'b0;
        read_chk(1, 11'h054, "R8 busy input ignored in master mode");
    endtask

    initial begin
        idle();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_simul();
        t_stagger();
        t_loser_read();
        t_slave();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule